// File: doc/BRIEF.md
# I2C Slave Receiver

This block is the receive half of an I2C-bus slave. Software gives it a 7-bit own address, a general-call enable, a block enable and an acknowledge enable. The block watches the external SCL and SDA lines and detects START and STOP conditions. It shifts in the address byte and acknowledges it when the address matches and the direction bit requests a write. It then takes data bytes from the external master transmitter. Each byte is acknowledged or not, depending on the acknowledge enable.

Every bus event that concerns the slave ends in a stop point. The interrupt flag rises, a status code describes the event, and SCL is held low until software clears the flag. Bit timing comes only from the external SCL; there is no rate setting. An input from the master side marks an addressing that follows a lost arbitration, and the slave then reports distinct status codes.

Top module: `i2cSlaveRx`

## Requirements
- R1: An address byte whose upper 7 bits equal cfgAddr[7:1] and whose bit 0 is 0 (write) is acknowledged. The block pulls SDA low during the ninth clock. After the ninth SCL fall, irqFlag is 1 and status is 0x60.
- R2: Address 0x00 with a write bit (the general call) is acknowledged with status 0x70 only when cfgAddr[0] is 1. When cfgAddr[0] is 0, it is not acknowledged and irqFlag stays 0.
- R3: A different address, or the own address with bit 0 = 1 (read), is not acknowledged. No flag is raised, and the data bytes that follow are ignored until the next START.
- R4: After an acknowledged data byte, rxData holds the byte (MSB first on the bus). Status is 0x80 in an own-address transfer and 0x90 in a general-call transfer.
- R5: If ctlAck is 0 when a data byte completes, SDA stays high in the ninth clock. Status is 0x88 (own) or 0x98 (general call), and later bytes are ignored until the next START.
- R6: While ctlAck is 0, neither the own address nor the general call is acknowledged. Once ctlAck is set again, the next START with a matching address is recognised.
- R7: When lostArb is 1 at addressing, the status codes are 0x68 (own address) and 0x78 (general call) in place of 0x60 and 0x70.
- R8: A STOP or a repeated START while addressed sets irqFlag with status 0xA0. After a repeated START, the next address byte is recognised as usual.
- R9: While irqFlag is 1, sclOe is 1 and irqFlag stays set until a flagClear pulse. While irqFlag is 0, status reads 0xF8 and sclOe is 0.
- R10: sdaOe changes only while SCL is low, and it is 0 whenever irqFlag is 1.
- R11: With ctlEnable at 0, the block acknowledges nothing and raises no flag.
- R12: After reset, irqFlag, sdaOe and sclOe are 0 and status is 0xF8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| ctlEnable | input | 1 | Block enable |
| ctlAck | input | 1 | Acknowledge enable |
| cfgAddr | input | 8 | Own address in [7:1], general-call enable in [0] |
| lostArb | input | 1 | Addressing follows a lost arbitration |
| flagClear | input | 1 | One-cycle pulse that clears irqFlag |
| sclIn | input | 1 | SCL line level |
| sdaIn | input | 1 | SDA line level |
| sclOe | output | 1 | Pull SCL low (clock stretch) |
| sdaOe | output | 1 | Pull SDA low (acknowledge) |
| irqFlag | output | 1 | Interrupt flag |
| status | output | 8 | Status code |
| rxData | output | 8 | Last received data byte |

## Verification
A vector table sends address bytes that match the own address, the general call with the enable both on and off, a mismatching address and a read request. The same table covers lostArb set and clear and ctlAck cleared. Together these separate the acknowledge decision from the status-code choice. Directed sequences withdraw the acknowledge in the middle of a transfer for both own-address and general-call modes, and show that later bytes are ignored. They also show recognition resuming after ctlAck returns, a repeated START while addressed, and a disabled block.

// File: rtl/i2cRxPkg.sv
package i2cRxPkg;
  localparam int BYTE_W = 8;
  localparam int CNT_W  = $clog2(BYTE_W + 1);

  localparam logic [7:0] CODE_OWN     = 8'h60;
  localparam logic [7:0] CODE_OWN_ARB = 8'h68;
  localparam logic [7:0] CODE_GC      = 8'h70;
  localparam logic [7:0] CODE_GC_ARB  = 8'h78;
  localparam logic [7:0] CODE_OWN_ACK = 8'h80;
  localparam logic [7:0] CODE_OWN_NAK = 8'h88;
  localparam logic [7:0] CODE_GC_ACK  = 8'h90;
  localparam logic [7:0] CODE_GC_NAK  = 8'h98;
  localparam logic [7:0] CODE_END     = 8'hA0;
  localparam logic [7:0] CODE_NONE    = 8'hF8;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_ACKA, ST_DATA, ST_ACKD, ST_WAIT
  } rxStateT;

  typedef struct packed {
    logic       cntClr;
    logic       shift;
    logic       latchData;
    logic       setFlag;
    logic [7:0] code;
  } rxStrobeT;
endpackage

// File: rtl/i2cRxDatapath.sv
module i2cRxDatapath
  import i2cRxPkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  rxStrobeT          stb,
  input  logic              flagClear,
  output logic              sclRise,
  output logic              sclFall,
  output logic              startDet,
  output logic              stopDet,
  output logic [BYTE_W-1:0] shiftReg,
  output logic [CNT_W-1:0]  bitCnt,
  output logic              irqFlag,
  output logic [7:0]        status,
  output logic [BYTE_W-1:0] rxData
);
  logic [SYNC_STAGES-1:0] sclPipe, sdaPipe;
  logic sclS, sdaS, sclP, sdaP;
  logic [7:0] statusReg;

  generate
    for (genvar g = 0; g < SYNC_STAGES; g++) begin : gSync
      if (g == 0) begin : gFirst
        always_ff @(posedge clk or negedge rstN)
          if (!rstN) begin
            sclPipe[0] <= 1'b1;
            sdaPipe[0] <= 1'b1;
          end else begin
            sclPipe[0] <= sclIn;
            sdaPipe[0] <= sdaIn;
          end
      end else begin : gRest
        always_ff @(posedge clk or negedge rstN)
          if (!rstN) begin
            sclPipe[g] <= 1'b1;
            sdaPipe[g] <= 1'b1;
          end else begin
            sclPipe[g] <= sclPipe[g-1];
            sdaPipe[g] <= sdaPipe[g-1];
          end
      end
    end
  endgenerate

  assign sclS = sclPipe[SYNC_STAGES-1];
  assign sdaS = sdaPipe[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rstN)
    if (!rstN) begin
      sclP <= 1'b1;
      sdaP <= 1'b1;
    end else begin
      sclP <= sclS;
      sdaP <= sdaS;
    end

  assign sclRise  = sclS & ~sclP;
  assign sclFall  = ~sclS & sclP;
  assign startDet = sclS & sclP & sdaP & ~sdaS;
  assign stopDet  = sclS & sclP & ~sdaP & sdaS;

  always_ff @(posedge clk or negedge rstN)
    if (!rstN) begin
      shiftReg  <= '0;
      bitCnt    <= '0;
      rxData    <= '0;
      statusReg <= CODE_NONE;
      irqFlag   <= 1'b0;
    end else begin
      if (stb.cntClr) bitCnt <= '0;
      else if (stb.shift) bitCnt <= bitCnt + CNT_W'(1);
      if (stb.shift) shiftReg <= {shiftReg[BYTE_W-2:0], sdaS};
      if (stb.latchData) rxData <= shiftReg;
      if (stb.setFlag) begin
        irqFlag   <= 1'b1;
        statusReg <= stb.code;
      end else if (flagClear) begin
        irqFlag <= 1'b0;
      end
    end

  assign status = irqFlag ? statusReg : CODE_NONE;
endmodule

// File: rtl/i2cRxCtrl.sv
module i2cRxCtrl
  import i2cRxPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              ctlEnable,
  input  logic              ctlAck,
  input  logic              lostArb,
  input  logic [6:0]        ownAddr,
  input  logic              gcEn,
  input  logic              sclRise,
  input  logic              sclFall,
  input  logic              startDet,
  input  logic              stopDet,
  input  logic [BYTE_W-1:0] shiftReg,
  input  logic [CNT_W-1:0]  bitCnt,
  output rxStrobeT          stb,
  output logic              sdaOe
);
  rxStateT state, stateN;
  logic sdaN, gcSel, gcN;
  logic [7:0] pendCode, pendN;
  logic byteFull, addressed, ownHit, gcHit, accept;

  assign byteFull  = (bitCnt == CNT_W'(BYTE_W));
  assign addressed = (state == ST_DATA) || (state == ST_ACKD);
  assign ownHit    = (shiftReg[7:1] == ownAddr) && (ownAddr != 7'd0);
  assign gcHit     = (shiftReg[7:1] == 7'd0) && gcEn;
  assign accept    = ctlAck && !shiftReg[0] && (ownHit || gcHit);

  always_comb begin
    stateN   = state;
    sdaN     = sdaOe;
    gcN      = gcSel;
    pendN    = pendCode;
    stb      = '0;
    stb.code = pendCode;
    if (!ctlEnable) begin
      stateN = ST_IDLE;
      sdaN   = 1'b0;
    end else if (startDet) begin
      if (addressed) begin
        stb.setFlag = 1'b1;
        stb.code    = CODE_END;
      end
      stb.cntClr = 1'b1;
      stateN     = ST_ADDR;
      sdaN       = 1'b0;
    end else if (stopDet) begin
      if (addressed) begin
        stb.setFlag = 1'b1;
        stb.code    = CODE_END;
      end
      stateN = ST_IDLE;
      sdaN   = 1'b0;
    end else begin
      case (state)
        ST_ADDR: begin
          stb.shift = sclRise && !byteFull;
          if (sclFall && byteFull) begin
            if (accept) begin
              stateN = ST_ACKA;
              sdaN   = 1'b1;
              gcN    = gcHit && !ownHit;
              if (gcHit && !ownHit) pendN = lostArb ? CODE_GC_ARB : CODE_GC;
              else                  pendN = lostArb ? CODE_OWN_ARB : CODE_OWN;
            end else begin
              stateN = ST_WAIT;
            end
          end
        end
        ST_ACKA: if (sclFall) begin
          sdaN        = 1'b0;
          stb.setFlag = 1'b1;
          stb.cntClr  = 1'b1;
          stateN      = ST_DATA;
        end
        ST_DATA: begin
          stb.shift = sclRise && !byteFull;
          if (sclFall && byteFull) begin
            stb.latchData = 1'b1;
            stateN        = ST_ACKD;
            sdaN          = ctlAck;
            if (gcSel) pendN = ctlAck ? CODE_GC_ACK : CODE_GC_NAK;
            else       pendN = ctlAck ? CODE_OWN_ACK : CODE_OWN_NAK;
          end
        end
        ST_ACKD: if (sclFall) begin
          sdaN        = 1'b0;
          stb.setFlag = 1'b1;
          stb.cntClr  = 1'b1;
          stateN      = sdaOe ? ST_DATA : ST_WAIT;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN)
    if (!rstN) begin
      state    <= ST_IDLE;
      sdaOe    <= 1'b0;
      gcSel    <= 1'b0;
      pendCode <= CODE_NONE;
    end else begin
      state    <= stateN;
      sdaOe    <= sdaN;
      gcSel    <= gcN;
      pendCode <= pendN;
    end
endmodule

// File: rtl/i2cSlaveRx.sv
module i2cSlaveRx
  import i2cRxPkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       ctlEnable,
  input  logic       ctlAck,
  input  logic [7:0] cfgAddr,
  input  logic       lostArb,
  input  logic       flagClear,
  input  logic       sclIn,
  input  logic       sdaIn,
  output logic       sclOe,
  output logic       sdaOe,
  output logic       irqFlag,
  output logic [7:0] status,
  output logic [7:0] rxData
);
  rxStrobeT stb;
  logic sclRise, sclFall, startDet, stopDet;
  logic [BYTE_W-1:0] shiftReg;
  logic [CNT_W-1:0] bitCnt;

  i2cRxDatapath #(.SYNC_STAGES(SYNC_STAGES)) dp_i (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn), .stb(stb),
    .flagClear(flagClear), .sclRise(sclRise), .sclFall(sclFall),
    .startDet(startDet), .stopDet(stopDet), .shiftReg(shiftReg),
    .bitCnt(bitCnt), .irqFlag(irqFlag), .status(status), .rxData(rxData)
  );

  i2cRxCtrl ctrl_i (
    .clk(clk), .rstN(rstN), .ctlEnable(ctlEnable), .ctlAck(ctlAck),
    .lostArb(lostArb), .ownAddr(cfgAddr[7:1]), .gcEn(cfgAddr[0]),
    .sclRise(sclRise), .sclFall(sclFall), .startDet(startDet),
    .stopDet(stopDet), .shiftReg(shiftReg), .bitCnt(bitCnt),
    .stb(stb), .sdaOe(sdaOe)
  );

  assign sclOe = irqFlag;
endmodule

// File: rtl/i2cRxChecker.sv
module i2cRxChecker (
  input logic       clk,
  input logic       rstN,
  input logic       sclIn,
  input logic       ctlEnable,
  input logic       flagClear,
  input logic       irqFlag,
  input logic       sdaOe,
  input logic [7:0] status
);
  assert_flag_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    irqFlag && !flagClear |=> irqFlag);

  assert_idle_code_R9: assert property (@(posedge clk) disable iff (!rstN)
    !irqFlag |-> status == 8'hF8);

  assert_sda_edge_R10: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(sdaOe) |-> !sclIn);

  assert_sda_free_R10: assert property (@(posedge clk) disable iff (!rstN)
    irqFlag |-> !sdaOe);

  assert_disabled_quiet_R11: assert property (@(posedge clk) disable iff (!rstN)
    !ctlEnable |=> !sdaOe);

  assert_code_valid_R4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irqFlag) |-> (status != 8'hF8) && (status[2:0] == 3'd0));
endmodule

bind i2cSlaveRx i2cRxChecker chk_i (
  .clk(clk), .rstN(rstN), .sclIn(sclIn), .ctlEnable(ctlEnable),
  .flagClear(flagClear), .irqFlag(irqFlag), .sdaOe(sdaOe), .status(status)
);

// File: tb/i2cSlaveRx_tb.sv
module i2cSlaveRx_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic ctlEnable = 1'b1, ctlAck = 1'b1, lostArb = 1'b0, flagClear = 1'b0;
  logic [7:0] cfgAddr = 8'h54;
  logic mScl = 1'b1, mSda = 1'b1;
  logic sclOe, sdaOe, irqFlag;
  logic [7:0] status, rxData;
  wire sclLine = mScl & ~sclOe;
  wire sdaLine = mSda & ~sdaOe;
  int total = 0, bad = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  i2cSlaveRx dut_i (
    .clk(clk), .rstN(rstN), .ctlEnable(ctlEnable), .ctlAck(ctlAck),
    .cfgAddr(cfgAddr), .lostArb(lostArb), .flagClear(flagClear),
    .sclIn(sclLine), .sdaIn(sdaLine), .sclOe(sclOe), .sdaOe(sdaOe),
    .irqFlag(irqFlag), .status(status), .rxData(rxData)
  );

  // {cfgAddr, addrByte, ctlAck, lostArb, expAck, addrCode, dataCode}
  localparam logic [34:0] VEC [8] = '{
    {8'h54, 8'h54, 1'b1, 1'b0, 1'b1, 8'h60, 8'h80},
    {8'h55, 8'h00, 1'b1, 1'b0, 1'b1, 8'h70, 8'h90},
    {8'h54, 8'h00, 1'b1, 1'b0, 1'b0, 8'hF8, 8'hF8},
    {8'h54, 8'h55, 1'b1, 1'b0, 1'b0, 8'hF8, 8'hF8},
    {8'h54, 8'h56, 1'b1, 1'b0, 1'b0, 8'hF8, 8'hF8},
    {8'h54, 8'h54, 1'b1, 1'b1, 1'b1, 8'h68, 8'h80},
    {8'h55, 8'h00, 1'b1, 1'b1, 1'b1, 8'h78, 8'h90},
    {8'h54, 8'h54, 1'b0, 1'b0, 1'b0, 8'hF8, 8'hF8}
  };

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic sclHigh();
    mScl = 1'b1;
    while (!sclLine) waitClk(1);
    waitClk(6);
  endtask

  task automatic busStart();
    mSda = 1'b1; waitClk(6);
    sclHigh();
    mSda = 1'b0; waitClk(6);
    mScl = 1'b0; waitClk(6);
  endtask

  task automatic busStop();
    mSda = 1'b0; waitClk(6);
    sclHigh();
    mSda = 1'b1; waitClk(10);
  endtask

  task automatic sendByte(input logic [7:0] b, output logic acked);
    for (int i = 7; i >= 0; i--) begin
      mSda = b[i]; waitClk(3);
      sclHigh();
      mScl = 1'b0; waitClk(3);
    end
    mSda = 1'b1; waitClk(3);
    mScl = 1'b1;
    while (!sclLine) waitClk(1);
    waitClk(3);
    acked = !sdaLine;
    waitClk(3);
    mScl = 1'b0; waitClk(10);
  endtask

  task automatic clearFlag();
    flagClear = 1'b1; waitClk(1);
    flagClear = 1'b0; waitClk(4);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic a;
    string tag;
    waitClk(4);
    // R12: reset state
    chk(irqFlag == 0 && sdaOe == 0 && sclOe == 0, "R12 outputs", {irqFlag, sdaOe, sclOe}, 0);
    chk(status == 8'hF8, "R12 status", status, 8'hF8);
    rstN = 1'b1;
    waitClk(4);

    for (int v = 0; v < 8; v++) begin
      logic [7:0] dByte;
      cfgAddr = VEC[v][34:27];
      ctlAck  = VEC[v][18];
      lostArb = VEC[v][17];
      dByte   = 8'hA5 ^ 8'(v * 17);
      if (VEC[v][17])               tag = "R7";
      else if (!VEC[v][18])         tag = "R6";
      else if (VEC[v][26:19] == 0)  tag = "R2";
      else if (VEC[v][16])          tag = "R1";
      else                          tag = "R3";
      busStart();
      sendByte(VEC[v][26:19], a);
      chk(a == VEC[v][16], {tag, " addr ack"}, a, VEC[v][16]);
      waitClk(4);
      if (VEC[v][16]) begin
        chk(irqFlag && status == VEC[v][15:8], {tag, " addr code"}, status, VEC[v][15:8]);
        chk(sclOe == 1'b1 && sclLine == 1'b0, "R9 stretch", sclOe, 1);
        clearFlag();
        chk(status == 8'hF8 && sclOe == 0, "R9 released", {sclOe, status}, 8'hF8);
        sendByte(dByte, a);
        waitClk(4);
        chk(a == 1'b1, "R4 data ack", a, 1);
        chk(status == VEC[v][7:0], "R4 data code", status, VEC[v][7:0]);
        chk(rxData == dByte, "R4 rxData", rxData, dByte);
        clearFlag();
        busStop();
        chk(irqFlag && status == 8'hA0, "R8 stop code", status, 8'hA0);
        clearFlag();
      end else begin
        chk(!irqFlag && status == 8'hF8, {tag, " no flag"}, status, 8'hF8);
        sendByte(dByte, a);
        waitClk(4);
        chk(!a && !irqFlag, {tag, " data ignored"}, {a, irqFlag}, 0);
        busStop();
        chk(!irqFlag, {tag, " stop quiet"}, irqFlag, 0);
      end
    end
    lostArb = 1'b0;
    ctlAck  = 1'b1;

    // R5: acknowledge withdrawn mid-transfer, own address
    cfgAddr = 8'h54;
    busStart(); sendByte(8'h54, a); waitClk(4); clearFlag();
    ctlAck = 1'b0;
    sendByte(8'h11, a); waitClk(4);
    chk(!a, "R5 nack", a, 0);
    chk(status == 8'h88 && rxData == 8'h11, "R5 own nack code", status, 8'h88);
    clearFlag();
    sendByte(8'h22, a); waitClk(4);
    chk(!a && !irqFlag, "R5 later bytes ignored", {a, irqFlag}, 0);
    busStop();
    chk(!irqFlag, "R5 stop quiet", irqFlag, 0);

    // R5: general call variant
    ctlAck = 1'b1; cfgAddr = 8'h55;
    busStart(); sendByte(8'h00, a); waitClk(4); clearFlag();
    ctlAck = 1'b0;
    sendByte(8'h33, a); waitClk(4);
    chk(!a && status == 8'h98, "R5 gc nack code", status, 8'h98);
    clearFlag(); busStop();

    // R6: resume after ack re-enabled; R8: repeated start
    busStart(); sendByte(8'h54, a); waitClk(4);
    chk(!a && !irqFlag, "R6 isolated", {a, irqFlag}, 0);
    busStop();
    ctlAck = 1'b1;
    busStart(); sendByte(8'h54, a); waitClk(4);
    chk(a && status == 8'h60, "R6 resumed", status, 8'h60);
    clearFlag();
    busStart(); waitClk(4);
    chk(irqFlag && status == 8'hA0, "R8 repeated start", status, 8'hA0);
    clearFlag();
    sendByte(8'h54, a); waitClk(4);
    chk(a && status == 8'h60, "R8 readdressed", status, 8'h60);
    clearFlag(); busStop(); clearFlag();

    // R11: disabled block
    ctlEnable = 1'b0;
    busStart(); sendByte(8'h54, a); waitClk(4);
    chk(!a && !irqFlag, "R11 disabled", {a, irqFlag}, 0);
    busStop();
    chk(!irqFlag && status == 8'hF8, "R11 quiet", status, 8'hF8);

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule